// File: doc/BRIEF.md
# Tight Loop Mode Controller

This controller sits next to the decode stage of a small processor front end and watches the stream of decoded instructions. It looks for a one-instruction loop: a single-word instruction that does not change program flow, followed at once by a decrement-and-branch whose 16-bit displacement points back to that instruction. When the branch is taken, the controller keeps the body word in a one-word buffer. It then holds off all instruction fetches and replays the buffered word, so that only the body's data cycles use the bus.

A shadow of the loop counter lives inside the block. At each completed iteration, signalled by the execution side, the controller decides whether to go round again or leave. It leaves when the branch condition is true or when the decremented count wraps to all ones. On a normal exit it releases the fetch hold in the same cycle and sends a one-cycle restart request carrying the fall-through address. An exception or interrupt request also drops the controller out of loop mode at once, but it sends no restart request, because exception processing redirects the fetch stream itself.

Top module: `tight_loop_ctrl`

## Requirements
- R1: While reset is asserted, loop_active, fetch_hold, replay_valid and restart_pulse are 0, and loop_count, replay_word and restart_addr are 0.
- R2: A decoded decrement-and-branch (dec_dbra=1) enters loop mode on the next cycle only if all of the following hold: dec_disp is 16'hFFFC; the previous decoded instruction had dec_single=1 and dec_flow=0; cond_true=0; count_in is not 0. After entry, loop_count equals count_in-1 and replay_word equals the previous instruction's dec_word.
- R3: A decrement-and-branch does not enter loop mode in any of these cases: its displacement is not 16'hFFFC; the previous decoded instruction was multi-word or flow-changing; no instruction was decoded after the last exit.
- R4: In every cycle with loop_active=1 and no exit, fetch_hold=1 and replay_valid=1.
- R5: An iteration (iter_done=1) with cond_true=0, loop_count not 0 and exc_req=0 decrements loop_count by one, and loop mode continues.
- R6: An iteration with cond_true=1 (loop_count unchanged), or with loop_count=0 (loop_count becomes 16'hFFFF), ends the loop. In that same cycle fetch_hold and replay_valid are 0, and restart_pulse is 1 for exactly one cycle with restart_addr equal to the branch address plus 4. loop_active is 0 on the next cycle.
- R7: exc_req=1 while loop_active=1 drops fetch_hold and replay_valid in the same cycle. It gives no restart_pulse and leaves loop_count unchanged, and loop_active is 0 on the next cycle. This also holds when an iteration would have ended the loop in that cycle.
- R8: A qualifying decrement-and-branch decoded while loop mode is active is ignored: loop_count, replay_word and restart_addr do not change.
- R9: Pair tracking is suspended during loop mode, so re-entry after an exit needs a fresh body instruction to be decoded before the next decrement-and-branch.
- R10: iter_done has no effect outside loop mode: no restart_pulse, and loop_count is unchanged.
- R11: exc_req=1 in the cycle of a qualifying decrement-and-branch blocks entry.
- R12: A decrement-and-branch that is not taken (cond_true=1, or count_in=0) does not enter loop mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_valid | input | 1 | A decoded instruction is presented this cycle |
| dec_word | input | 16 | First word of the decoded instruction |
| dec_addr | input | 32 | Byte address of the decoded instruction |
| dec_single | input | 1 | Instruction is one word long |
| dec_flow | input | 1 | Instruction changes program flow |
| dec_dbra | input | 1 | Instruction is a decrement-and-branch |
| dec_disp | input | 16 | Branch displacement of the decrement-and-branch |
| cond_true | input | 1 | Branch termination condition result |
| count_in | input | 16 | Loop counter value before decrement, at entry |
| iter_done | input | 1 | Data operations of one loop iteration completed |
| exc_req | input | 1 | Interrupt or other exception request |
| fetch_hold | output | 1 | Suppress instruction fetches |
| replay_valid | output | 1 | Buffered body word is offered for execution |
| replay_word | output | 16 | Buffered body word |
| loop_active | output | 1 | Loop mode status |
| loop_count | output | 16 | Shadow loop counter |
| restart_pulse | output | 1 | One-cycle fetch restart request on loop termination |
| restart_addr | output | 32 | Fall-through address for the restart |

## Verification
The key collision is an exception request that lands in the same cycle as an iteration that would end the loop. That cycle could call for a restart request and for a silent exception exit at once. The bench sets this up directly, with iter_done, a true condition and exc_req all high while looping. It also reaches the case by chance in the random phase. The expected result is a released fetch hold with no restart pulse and an unchanged counter. A second overlap is a new qualifying branch arriving in the cycle an iteration ends. The bench's model expects that branch to be ignored, because the controller is still active during that cycle.

// File: rtl/tlm_pkg.sv
package tlm_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_LOOP = 1'b1
  } tlm_state_e;

  typedef enum logic [1:0] {
    EXIT_NONE = 2'd0,
    EXIT_TERM = 2'd1,
    EXIT_EXC  = 2'd2
  } tlm_exit_e;
endpackage

// File: rtl/tlm_pair_track.sv
module tlm_pair_track #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              track_en,
  input  logic              dec_valid,
  input  logic              dec_single,
  input  logic              dec_flow,
  input  logic [WORD_W-1:0] dec_word,
  output logic              prev_ok,
  output logic [WORD_W-1:0] prev_word
);
  logic              ok_nxt;
  logic              word_en;
  logic [WORD_W-1:0] word_nxt;

  always_comb begin
    ok_nxt   = prev_ok;
    word_en  = 1'b0;
    word_nxt = prev_word;
    if (!track_en) begin
      ok_nxt = 1'b0;
    end else if (dec_valid) begin
      ok_nxt   = dec_single & ~dec_flow;
      word_en  = 1'b1;
      word_nxt = dec_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_ok   <= 1'b0;
      prev_word <= '0;
    end else begin
      prev_ok <= ok_nxt;
      if (word_en) begin
        prev_word <= word_nxt;
      end
    end
  end
endmodule

// File: rtl/tlm_entry_qual.sv
module tlm_entry_qual #(
  parameter int          DISP_W    = 16,
  parameter int          CNT_W     = 16,
  parameter logic [15:0] LOOP_DISP = 16'hFFFC
) (
  input  logic              active,
  input  logic              dec_valid,
  input  logic              dec_dbra,
  input  logic [DISP_W-1:0] dec_disp,
  input  logic              prev_ok,
  input  logic              cond_true,
  input  logic [CNT_W-1:0]  count_in,
  input  logic              exc_req,
  output logic              enter
);
  localparam logic [DISP_W-1:0] DISP_MATCH = DISP_W'(LOOP_DISP);

  logic candidate;
  logic taken;

  always_comb begin
    candidate = dec_valid & dec_dbra & (dec_disp == DISP_MATCH) & prev_ok;
    taken     = ~cond_true & (count_in != '0);
    enter     = ~active & candidate & taken & ~exc_req;
  end
endmodule

// File: rtl/tlm_iter_ctr.sv
module tlm_iter_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             step,
  output logic [CNT_W-1:0] cnt,
  output logic             at_last
);
  logic             cnt_en;
  logic [CNT_W-1:0] cnt_nxt;

  always_comb begin
    cnt_en  = load | step;
    cnt_nxt = cnt;
    if (load) begin
      cnt_nxt = load_val;
    end else if (step) begin
      cnt_nxt = cnt - 1'b1;
    end
    at_last = (cnt == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (cnt_en) begin
      cnt <= cnt_nxt;
    end
  end
endmodule

// File: rtl/tlm_replay_buf.sv
module tlm_replay_buf #(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] word_in,
  input  logic [ADDR_W-1:0] fall_in,
  output logic [WORD_W-1:0] word_q,
  output logic [ADDR_W-1:0] fall_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      fall_q <= '0;
    end else if (load) begin
      word_q <= word_in;
      fall_q <= fall_in;
    end
  end
endmodule

// File: rtl/tight_loop_ctrl.sv
module tight_loop_ctrl
  import tlm_pkg::*;
#(
  parameter int          WORD_W     = 16,
  parameter int          ADDR_W     = 32,
  parameter int          CNT_W      = 16,
  parameter int          WORD_BYTES = 2,
  parameter logic [15:0] LOOP_DISP  = 16'hFFFC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dec_valid,
  input  logic [WORD_W-1:0] dec_word,
  input  logic [ADDR_W-1:0] dec_addr,
  input  logic              dec_single,
  input  logic              dec_flow,
  input  logic              dec_dbra,
  input  logic [WORD_W-1:0] dec_disp,
  input  logic              cond_true,
  input  logic [CNT_W-1:0]  count_in,
  input  logic              iter_done,
  input  logic              exc_req,
  output logic              fetch_hold,
  output logic              replay_valid,
  output logic [WORD_W-1:0] replay_word,
  output logic              loop_active,
  output logic [CNT_W-1:0]  loop_count,
  output logic              restart_pulse,
  output logic [ADDR_W-1:0] restart_addr
);
  localparam logic [ADDR_W-1:0] FALL_OFS = ADDR_W'(2 * WORD_BYTES);

  tlm_state_e        state_q, state_nxt;
  tlm_exit_e         exit_kind;
  logic              prev_ok;
  logic [WORD_W-1:0] prev_word;
  logic              enter;
  logic              at_last;
  logic              step;
  logic              active;

  assign active = (state_q == ST_LOOP);

  tlm_pair_track #(.WORD_W(WORD_W)) u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .track_en   (~active),
    .dec_valid  (dec_valid),
    .dec_single (dec_single),
    .dec_flow   (dec_flow),
    .dec_word   (dec_word),
    .prev_ok    (prev_ok),
    .prev_word  (prev_word)
  );

  tlm_entry_qual #(
    .DISP_W    (WORD_W),
    .CNT_W     (CNT_W),
    .LOOP_DISP (LOOP_DISP)
  ) u_qual (
    .active    (active),
    .dec_valid (dec_valid),
    .dec_dbra  (dec_dbra),
    .dec_disp  (dec_disp),
    .prev_ok   (prev_ok),
    .cond_true (cond_true),
    .count_in  (count_in),
    .exc_req   (exc_req),
    .enter     (enter)
  );

  // Exit decision: an exception outranks a terminating iteration.
  always_comb begin
    exit_kind = EXIT_NONE;
    if (active) begin
      if (exc_req) begin
        exit_kind = EXIT_EXC;
      end else if (iter_done && (cond_true || at_last)) begin
        exit_kind = EXIT_TERM;
      end
    end
    // The counter moves on every iteration whose condition is false.
    step = active & iter_done & ~exc_req & ~cond_true;
  end

  tlm_iter_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (enter),
    .load_val (count_in - 1'b1),
    .step     (step),
    .cnt      (loop_count),
    .at_last  (at_last)
  );

  tlm_replay_buf #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (enter),
    .word_in (prev_word),
    .fall_in (dec_addr + FALL_OFS),
    .word_q  (replay_word),
    .fall_q  (restart_addr)
  );

  always_comb begin
    state_nxt = state_q;
    case (state_q)
      ST_IDLE: if (enter) state_nxt = ST_LOOP;
      ST_LOOP: if (exit_kind != EXIT_NONE) state_nxt = ST_IDLE;
      default: state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_nxt;
    end
  end

  assign loop_active   = active;
  assign fetch_hold    = active & (exit_kind == EXIT_NONE);
  assign replay_valid  = active & (exit_kind == EXIT_NONE);
  assign restart_pulse = (exit_kind == EXIT_TERM);
endmodule

// File: rtl/tight_loop_ctrl_chk.sv
module tight_loop_ctrl_chk #(
  parameter int WORD_W = 16,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cond_true,
  input logic              iter_done,
  input logic              exc_req,
  input logic              fetch_hold,
  input logic              replay_valid,
  input logic [WORD_W-1:0] replay_word,
  input logic              loop_active,
  input logic [CNT_W-1:0]  loop_count,
  input logic              restart_pulse
);
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_active && !exc_req && !iter_done) |-> (fetch_hold && replay_valid));

  assert_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_active && iter_done && !exc_req && !cond_true && loop_count != '0)
      |=> (loop_active && loop_count == CNT_W'($past(loop_count) - 1'b1)));

  assert_pulse_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    restart_pulse |-> (!fetch_hold && !replay_valid));

  assert_pulse_exit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    restart_pulse |=> (!loop_active && !restart_pulse));

  assert_exc_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_active && exc_req) |-> (!restart_pulse && !fetch_hold));

  assert_exc_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_active && exc_req) |=> !loop_active);

  assert_word_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_active && $past(loop_active)) |-> $stable(replay_word));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !loop_active |-> (!fetch_hold && !replay_valid && !restart_pulse));
endmodule

bind tight_loop_ctrl tight_loop_ctrl_chk #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cond_true     (cond_true),
  .iter_done     (iter_done),
  .exc_req       (exc_req),
  .fetch_hold    (fetch_hold),
  .replay_valid  (replay_valid),
  .replay_word   (replay_word),
  .loop_active   (loop_active),
  .loop_count    (loop_count),
  .restart_pulse (restart_pulse)
);

// File: tb/tight_loop_ctrl_test.sv
`timescale 1ns/1ps
module tight_loop_ctrl_test;
  logic        clk;
  logic        rst_n;
  logic        dec_valid, dec_single, dec_flow, dec_dbra;
  logic [15:0] dec_word, dec_disp, count_in;
  logic [31:0] dec_addr;
  logic        cond_true, iter_done, exc_req;
  logic        fetch_hold, replay_valid, loop_active, restart_pulse;
  logic [15:0] replay_word, loop_count;
  logic [31:0] restart_addr;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  string scen = "";

  // reference model state
  bit          m_active, m_prev_ok;
  logic [15:0] m_cnt, m_word, m_prev_word;
  logic [31:0] m_fall;

  tight_loop_ctrl uut (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s [%s]: actual %h expected %h", req, scen, got, exp);
    end
  endtask

  task automatic idle_in();
    dec_valid = 0; dec_single = 0; dec_flow = 0; dec_dbra = 0;
    dec_word = 16'h0; dec_disp = 16'h0; dec_addr = 32'h0;
    cond_true = 0; count_in = 16'h0; iter_done = 0; exc_req = 0;
  endtask

  task automatic body(logic [15:0] w, logic [31:0] a, bit single, bit flow);
    dec_valid = 1; dec_single = single; dec_flow = flow; dec_dbra = 0;
    dec_word = w; dec_addr = a; dec_disp = 16'h0;
  endtask

  task automatic dbra(logic [31:0] a, logic [15:0] disp, logic [15:0] cnt, bit ct);
    dec_valid = 1; dec_single = 0; dec_flow = 1; dec_dbra = 1;
    dec_word = 16'h51C8; dec_addr = a; dec_disp = disp; count_in = cnt; cond_true = ct;
  endtask

  function automatic bit f_exit_exc();
    return m_active && exc_req;
  endfunction

  function automatic bit f_exit_term();
    return m_active && !exc_req && iter_done && (cond_true || m_cnt == 16'h0);
  endfunction

  // one clock: compare before the edge, then advance the model
  task automatic cyc();
    bit xe, xt, enter;
    @(negedge clk); #1;
    xe = f_exit_exc();
    xt = f_exit_term();
    check("R2 loop_active", {31'b0, loop_active}, {31'b0, m_active});
    check("R4 fetch_hold", {31'b0, fetch_hold}, {31'b0, m_active && !xe && !xt});
    check("R4 replay_valid", {31'b0, replay_valid}, {31'b0, m_active && !xe && !xt});
    check("R6 restart_pulse", {31'b0, restart_pulse}, {31'b0, xt});
    check("R5 loop_count", {16'b0, loop_count}, {16'b0, m_cnt});
    if (m_active) check("R2 replay_word", {16'b0, replay_word}, {16'b0, m_word});
    if (xt) check("R6 restart_addr", restart_addr, m_fall);
    @(posedge clk); #1;
    if (m_active) begin
      if (iter_done && !exc_req && !cond_true) m_cnt = m_cnt - 16'h1;
      if (xe || xt) m_active = 0;
      m_prev_ok = 0;
    end else begin
      enter = dec_valid && dec_dbra && dec_disp == 16'hFFFC && m_prev_ok &&
              !cond_true && count_in != 16'h0 && !exc_req;
      if (enter) begin
        m_active = 1; m_cnt = count_in - 16'h1; m_word = m_prev_word;
        m_fall = dec_addr + 32'd4;
      end
      if (dec_valid) begin
        m_prev_ok = dec_single && !dec_flow;
        m_prev_word = dec_word;
      end
    end
  endtask

  task automatic iter(bit ct, bit ex);
    idle_in(); iter_done = 1; cond_true = ct; exc_req = ex; cyc();
  endtask

  initial begin
    void'($urandom(32'd2718));
    idle_in();
    m_active = 0; m_prev_ok = 0; m_cnt = 0; m_word = 0; m_prev_word = 0; m_fall = 0;
    rst_n = 0;
    #3;
    scen = "R1 reset";
    check("R1 loop_active", {31'b0, loop_active}, 0);
    check("R1 fetch_hold", {31'b0, fetch_hold}, 0);
    check("R1 replay_valid", {31'b0, replay_valid}, 0);
    check("R1 restart_pulse", {31'b0, restart_pulse}, 0);
    check("R1 loop_count", {16'b0, loop_count}, 0);
    check("R1 replay_word", {16'b0, replay_word}, 0);
    check("R1 restart_addr", restart_addr, 0);
    repeat (2) @(posedge clk);
    #1 rst_n = 1;

    // R2 R5 R6: count-out exit
    scen = "R2 entry then R6 count exit";
    body(16'h1234, 32'h100, 1, 0); cyc();
    dbra(32'h102, 16'hFFFC, 16'd3, 0); cyc();
    check("R2 entered count", {16'b0, loop_count}, 32'd2);
    idle_in(); cyc();
    iter(0, 0); iter(0, 0);
    check("R5 decremented", {16'b0, loop_count}, 32'd0);
    iter(0, 0);
    check("R6 wrap count", {16'b0, loop_count}, 32'hFFFF);
    idle_in(); cyc();

    // R9: branch right after exit has no fresh body
    scen = "R9 no fresh pair";
    dbra(32'h102, 16'hFFFC, 16'd5, 0); cyc(); idle_in(); cyc();

    // R6 condition exit, R8 second candidate ignored
    scen = "R8 candidate during loop";
    body(16'hABCD, 32'h200, 1, 0); cyc();
    dbra(32'h202, 16'hFFFC, 16'd9, 0); cyc();
    body(16'h5555, 32'h300, 1, 0); cyc();
    dbra(32'h302, 16'hFFFC, 16'd2, 0); cyc();
    check("R8 count kept", {16'b0, loop_count}, 32'd8);
    scen = "R6 condition exit";
    iter(0, 0); iter(1, 0);
    check("R6 count held on cond", {16'b0, loop_count}, 32'd7);

    // R7 exception exit, then exception colliding with termination
    scen = "R7 exception exit";
    body(16'h0F0F, 32'h400, 1, 0); cyc();
    dbra(32'h402, 16'hFFFC, 16'd4, 0); cyc();
    iter(0, 1);
    check("R7 count kept", {16'b0, loop_count}, 32'd3);
    scen = "R7 exception with termination";
    body(16'h0F0E, 32'h500, 1, 0); cyc();
    dbra(32'h502, 16'hFFFC, 16'd1, 0); cyc();
    iter(1, 1); idle_in(); cyc();

    // R3 R10 R11 R12 non-entries
    scen = "R3 bad displacement";
    body(16'h1111, 32'h600, 1, 0); cyc(); dbra(32'h602, 16'hFFFA, 16'd4, 0); cyc();
    scen = "R3 multiword body";
    body(16'h2222, 32'h600, 0, 0); cyc(); dbra(32'h604, 16'hFFFC, 16'd4, 0); cyc();
    scen = "R3 flow body";
    body(16'h3333, 32'h600, 1, 1); cyc(); dbra(32'h602, 16'hFFFC, 16'd4, 0); cyc();
    scen = "R11 exception at entry";
    body(16'h4444, 32'h600, 1, 0); cyc(); dbra(32'h602, 16'hFFFC, 16'd4, 0); exc_req = 1; cyc();
    scen = "R12 not taken";
    body(16'h6666, 32'h600, 1, 0); cyc(); dbra(32'h602, 16'hFFFC, 16'd0, 0); cyc();
    body(16'h6667, 32'h600, 1, 0); cyc(); dbra(32'h602, 16'hFFFC, 16'd4, 1); cyc();
    scen = "R10 idle iteration";
    iter(0, 0); iter(1, 0);
    check("R10 loop_active", {31'b0, loop_active}, 0);

    // random phase
    scen = "random";
    for (int i = 0; i < 4000; i++) begin
      int kind;
      idle_in();
      kind = $urandom % 4;
      dec_valid = ($urandom % 4) != 0;
      dec_addr  = {$urandom} & 32'hFFFF_FFFE;
      dec_word  = 16'($urandom);
      case (kind)
        0: begin dec_single = 1; dec_flow = 0; end
        1: begin dec_dbra = 1; dec_flow = 1;
                 dec_disp = (($urandom % 10) != 0) ? 16'hFFFC : 16'($urandom); end
        2: begin dec_single = 0; dec_flow = 0; end
        default: begin dec_single = 1; dec_flow = 1; end
      endcase
      cond_true = ($urandom % 6) == 0;
      count_in  = 16'($urandom % 5);
      iter_done = $urandom % 2;
      exc_req   = ($urandom % 40) == 0;
      cyc();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule